// File: doc/BRIEF.md
# TDM Audio Lane Serializer

This block is the transmit shifter of one serial audio data lane. A clock generator outside the block provides a one-cycle bit strobe for every bit period and a frame-start strobe that coincides with the bit strobe on the first bit of each frame. The serializer counts bit positions and slots inside the frame. At the head of every enabled slot it takes one 32-bit sample word from a valid/ready source. It then shifts the sample out MSB first on a single serial data pin, placed in the slot according to the selected justification.

Four framings are available: standard I2S (the data lags the frame edge by one bit), left-justified, right-justified and PCM. Samples are 16, 24 or 32 bits wide and are carried in 16- or 32-bit slots. A frame holds up to 16 slots, and a per-slot mask decides which of them carry data. When an enabled slot finds no word waiting, the lane sends silence for that slot and raises an underflow pulse. A frame-align option can hold the lane silent until the next frame, so that each word keeps its slot position.

Top module: `tdm_lane_serializer`

## Requirements
- R1: During and right after reset, `sdata_out`, `s_ready` and `underflow` are 0.
- R2: While `lane_en` is 0, `sdata_out`, `s_ready` and `underflow` stay 0. After `lane_en` rises, the lane stays silent and fetches nothing until a bit strobe arrives that has `frame_start` high.
- R3: The slot length is 32 bit periods when `dsize` is not 00 or when `slot32` is 1, and 16 otherwise. The frame has `slot_last`+1 slots. A bit strobe with `frame_start` high is bit 0 of slot 0. `sdata_out` changes only one clock after a bit strobe and holds between strobes.
- R4: Sample words are left-aligned in `s_data` and are sent MSB first. `dsize` 00 gives 16 data bits, 01 gives 24 and 10 gives 32. The reserved code 11 is treated as 32.
- R5: With `fmt`=01 (left-justified), the sample MSB occupies bit 0 of its slot, and the bits after the sample are 0.
- R6: With `fmt`=10 (right-justified), the sample LSB occupies the last bit of its slot, and the leading unused bits are 0.
- R7: With `fmt`=00 (standard I2S), the output is the left-justified stream delayed by one bit period. The first bit of a frame carries the last bit of the previous frame, which is 0 right after arming.
- R8: With `fmt`=11 (PCM), bit placement matches left-justified, so the MSB is on the frame edge.
- R9: Bit k of `slot_mask` enables slot k. A disabled slot outputs zeros and never asserts `s_ready`.
- R10: `s_ready` is high only during the bit strobe at bit 0 of an enabled slot of an armed lane. A word is consumed when `s_valid` is high in that cycle.
- R11: If `s_valid` is low when an enabled slot needs a word, the whole slot is 0 and `underflow` pulses for exactly one clock, one clock after that strobe.
- R12: With `frame_align`=1, an underflow suppresses all fetches and output until the next frame start. With `frame_align`=0, fetching resumes at the next enabled slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lane_en | input | 1 | Lane enable; clearing it idles and disarms the lane |
| fmt | input | 2 | Framing: 00 I2S, 01 left, 10 right, 11 PCM |
| dsize | input | 2 | Sample width: 00 16, 01 24, 10/11 32 bits |
| slot32 | input | 1 | Request 32-bit slots with 16-bit samples |
| slot_last | input | 4 | Number of slots per frame minus one |
| slot_mask | input | 16 | Per-slot enable |
| frame_align | input | 1 | Silence rest of frame after an underflow |
| bclk_tick | input | 1 | One-cycle strobe per bit period |
| frame_start | input | 1 | With `bclk_tick`, marks bit 0 of a frame |
| s_valid | input | 1 | Sample word available |
| s_data | input | 32 | Sample word, left-aligned |
| s_ready | output | 1 | Sample word taken this cycle |
| sdata_out | output | 1 | Serial data |
| underflow | output | 1 | One-clock pulse on a missed sample |

## Verification
The bench goes after the points where a slot begins. A one-bit error in the I2S delay would put every MSB on the frame edge, and the first bit of each frame would no longer carry the previous frame's last bit. It checks right-justified 16-bit samples in 32-bit slots, where a wrong lead count would shift the sample or leak word bits into the padding. Reserved size code 11 must behave as 32 bits rather than truncate. It also provokes underflows both with and without frame alignment. A design that lost alignment would keep fetching after a miss and move later words into the wrong slots. A design that ignored the mask would pull words for silent slots and drain the source early.

// File: rtl/tdm_ser_pkg.sv
package tdm_ser_pkg;
  localparam int WORD_W = 32;
  localparam int POS_W  = 5;
  localparam int LEN_W  = 6;

  typedef enum logic [1:0] {
    FMT_I2S   = 2'b00,
    FMT_LEFT  = 2'b01,
    FMT_RIGHT = 2'b10,
    FMT_PCM   = 2'b11
  } fmt_e;

  // Number of meaningful sample bits for a size code.
  function automatic logic [LEN_W-1:0] data_len(input logic [1:0] dsz);
    case (dsz)
      2'b00:   data_len = 6'd16;
      2'b01:   data_len = 6'd24;
      default: data_len = 6'd32;
    endcase
  endfunction

  // Slot length in bit periods; wider samples force 32-bit slots.
  function automatic logic [LEN_W-1:0] slot_len(input logic [1:0] dsz, input logic wide);
    slot_len = (wide || (dsz != 2'b00)) ? 6'd32 : 6'd16;
  endfunction

  // Bit of a left-aligned word that belongs at position pos of a slot.
  function automatic logic pick_bit(input logic [WORD_W-1:0] w,
                                    input logic [POS_W-1:0]  pos,
                                    input logic              right,
                                    input logic [LEN_W-1:0]  dlen,
                                    input logic [LEN_W-1:0]  slen);
    logic [LEN_W-1:0] lead;
    logic [LEN_W-1:0] rel;
    logic [POS_W-1:0] idx;
    lead = right ? (slen - dlen) : '0;
    rel  = {1'b0, pos} - lead;
    idx  = 5'd31 - rel[POS_W-1:0];
    if (({1'b0, pos} < lead) || (rel >= dlen)) pick_bit = 1'b0;
    else                                       pick_bit = w[idx];
  endfunction
endpackage

// File: rtl/tdm_slot_timer.sv
module tdm_slot_timer
  import tdm_ser_pkg::*;
#(
  parameter int SLOT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              frame_start,
  input  logic [SLOT_W-1:0] slot_last,
  input  logic [LEN_W-1:0]  slen,
  output logic [POS_W-1:0]  cur_pos,
  output logic [SLOT_W-1:0] cur_slot,
  output logic              slot_head
);
  logic [POS_W-1:0]  pos_q;
  logic [SLOT_W-1:0] slot_q;
  logic [LEN_W-1:0]  last_pos;
  logic              slot_end;

  assign cur_pos   = (tick && frame_start) ? '0 : pos_q;
  assign cur_slot  = (tick && frame_start) ? '0 : slot_q;
  assign slot_head = (cur_pos == '0);
  assign last_pos  = slen - 6'd1;
  assign slot_end  = ({1'b0, cur_pos} == last_pos);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q  <= '0;
      slot_q <= '0;
    end else if (tick) begin
      if (slot_end) begin
        pos_q  <= '0;
        slot_q <= (cur_slot == slot_last) ? '0 : cur_slot + 1'b1;
      end else begin
        pos_q  <= cur_pos + 1'b1;
        slot_q <= cur_slot;
      end
    end
  end

  // R3
  counters_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> ($stable(pos_q) && $stable(slot_q)));
  // R3
  slot_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !frame_start && !slot_end) |=> $stable(slot_q));
endmodule

// File: rtl/tdm_fetch_ctrl.sv
module tdm_fetch_ctrl
  import tdm_ser_pkg::*;
#(
  parameter int MAX_SLOTS = 16,
  parameter int SLOT_W    = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 lane_en,
  input  logic                 tick,
  input  logic                 frame_start,
  input  logic                 frame_align,
  input  logic [MAX_SLOTS-1:0] slot_mask,
  input  logic [SLOT_W-1:0]    cur_slot,
  input  logic                 slot_head,
  input  logic                 s_valid,
  input  logic [WORD_W-1:0]    s_data,
  output logic                 s_ready,
  output logic                 live_now,
  output logic [WORD_W-1:0]    word_now,
  output logic                 miss_evt
);
  logic              armed_q, skip_q, live_q;
  logic [WORD_W-1:0] word_q;
  logic              fs_tick, armed_now, skip_now, need, take;

  assign fs_tick   = tick && frame_start;
  assign armed_now = lane_en && (armed_q || fs_tick);
  assign skip_now  = fs_tick ? 1'b0 : skip_q;
  assign need      = tick && armed_now && slot_head && slot_mask[cur_slot] && !skip_now;
  assign take      = need && s_valid;
  assign miss_evt  = need && !s_valid;
  assign s_ready   = take;
  assign live_now  = slot_head ? take : live_q;
  assign word_now  = take ? s_data : word_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      skip_q  <= 1'b0;
      live_q  <= 1'b0;
      word_q  <= '0;
    end else if (!lane_en) begin
      armed_q <= 1'b0;
      skip_q  <= 1'b0;
      live_q  <= 1'b0;
    end else if (tick) begin
      armed_q <= armed_now;
      skip_q  <= (miss_evt && frame_align) ? 1'b1 : skip_now;
      if (slot_head) live_q <= take;
      if (take)      word_q <= s_data;
    end
  end

  // R10
  ready_on_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |-> (tick && slot_head && lane_en));
  // R9
  ready_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |-> slot_mask[cur_slot]);
  // R12
  skip_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (skip_q && !frame_start) |-> !s_ready);
endmodule

// File: rtl/tdm_lane_serializer.sv
module tdm_lane_serializer
  import tdm_ser_pkg::*;
#(
  parameter int MAX_SLOTS = 16,
  localparam int SLOT_W   = $clog2(MAX_SLOTS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 lane_en,
  input  logic [1:0]           fmt,
  input  logic [1:0]           dsize,
  input  logic                 slot32,
  input  logic [SLOT_W-1:0]    slot_last,
  input  logic [MAX_SLOTS-1:0] slot_mask,
  input  logic                 frame_align,
  input  logic                 bclk_tick,
  input  logic                 frame_start,
  input  logic                 s_valid,
  input  logic [WORD_W-1:0]    s_data,
  output logic                 s_ready,
  output logic                 sdata_out,
  output logic                 underflow
);
  logic [LEN_W-1:0]  slen, dlen;
  logic [POS_W-1:0]  cur_pos;
  logic [SLOT_W-1:0] cur_slot;
  logic              slot_head, live_now, miss_evt, base_bit;
  logic [WORD_W-1:0] word_now;
  logic              sd_q, dly_q, uf_q;

  assign slen = slot_len(dsize, slot32);
  assign dlen = data_len(dsize);

  tdm_slot_timer #(.SLOT_W(SLOT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .tick(bclk_tick), .frame_start(frame_start),
    .slot_last(slot_last), .slen(slen),
    .cur_pos(cur_pos), .cur_slot(cur_slot), .slot_head(slot_head)
  );

  tdm_fetch_ctrl #(.MAX_SLOTS(MAX_SLOTS), .SLOT_W(SLOT_W)) u_fetch (
    .clk(clk), .rst_n(rst_n), .lane_en(lane_en), .tick(bclk_tick),
    .frame_start(frame_start), .frame_align(frame_align), .slot_mask(slot_mask),
    .cur_slot(cur_slot), .slot_head(slot_head), .s_valid(s_valid), .s_data(s_data),
    .s_ready(s_ready), .live_now(live_now), .word_now(word_now), .miss_evt(miss_evt)
  );

  assign base_bit = live_now &&
                    pick_bit(word_now, cur_pos, fmt == FMT_RIGHT, dlen, slen);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sd_q  <= 1'b0;
      dly_q <= 1'b0;
      uf_q  <= 1'b0;
    end else begin
      uf_q <= miss_evt;
      if (!lane_en) begin
        sd_q  <= 1'b0;
        dly_q <= 1'b0;
      end else if (bclk_tick) begin
        dly_q <= base_bit;
        sd_q  <= (fmt == FMT_I2S) ? dly_q : base_bit;
      end
    end
  end

  assign sdata_out = sd_q;
  assign underflow = uf_q;

  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lane_en |=> (!sdata_out && !underflow));
  // R3
  hold_between_ticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_en && !bclk_tick) |=> $stable(sdata_out));
  // R11
  underflow_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    underflow |-> $past(bclk_tick && lane_en && !s_valid));
  // R11
  underflow_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    underflow |=> !underflow);
endmodule

// File: tb/tdm_lane_serializer_tb.sv
module tdm_lane_serializer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lane_en = 1'b0;
  logic [1:0]  fmt = 2'b01;
  logic [1:0]  dsize = 2'b00;
  logic        slot32 = 1'b0;
  logic [3:0]  slot_last = 4'd1;
  logic [15:0] slot_mask = 16'h3;
  logic        frame_align = 1'b0;
  logic        bclk_tick = 1'b0;
  logic        frame_start = 1'b0;
  logic        s_valid = 1'b0;
  logic [31:0] s_data = '0;
  logic        s_ready, sdata_out, underflow;

  int errors = 0;
  int checks = 0;

  // model state
  int m_pos = 0, m_slot = 0;
  bit m_armed = 0, m_skip = 0, m_live = 0, m_prev = 0;
  logic [31:0] m_word = '0;

  always #10 clk = ~clk;

  tdm_lane_serializer u_dut (
    .clk(clk), .rst_n(rst_n), .lane_en(lane_en), .fmt(fmt), .dsize(dsize),
    .slot32(slot32), .slot_last(slot_last), .slot_mask(slot_mask),
    .frame_align(frame_align), .bclk_tick(bclk_tick), .frame_start(frame_start),
    .s_valid(s_valid), .s_data(s_data), .s_ready(s_ready),
    .sdata_out(sdata_out), .underflow(underflow)
  );

  task automatic ck(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  function automatic int cfg_slot_len();
    return (dsize != 2'b00 || slot32) ? 32 : 16;
  endfunction

  function automatic int cfg_data_len();
    return (dsize == 2'b00) ? 16 : (dsize == 2'b01) ? 24 : 32;
  endfunction

  // R4 R5 R6 R8: expected bit at slot position pos, built as a slot image
  function automatic bit model_bit(logic [31:0] w, int pos);
    int L = cfg_slot_len();
    int D = cfg_data_len();
    logic [31:0] img;
    if (fmt == 2'b10) begin
      img = w >> (32 - D);
      return img[L - 1 - pos];
    end
    img = (D == 32) ? w : (w & ~((32'h1 << (32 - D)) - 32'h1));
    return img[31 - pos];
  endfunction

  function automatic string fmt_req();
    case (fmt)
      2'b00: return "R7";
      2'b01: return (dsize == 2'b11) ? "R4" : "R5";
      2'b10: return "R6";
      default: return "R8";
    endcase
  endfunction

  // One bit period: strobe cycle then one quiet cycle. Entered at a negedge.
  task automatic do_tick(input bit fs, input bit vld);
    bit need, take, miss, base, exp_out;
    string rq;
    logic [31:0] d;
    d = $urandom;
    bclk_tick = 1'b1; frame_start = fs; s_valid = vld; s_data = d;
    if (!lane_en) begin
      m_armed = 0; m_skip = 0; m_live = 0; m_prev = 0;
    end
    if (fs) begin m_pos = 0; m_slot = 0; m_skip = 0; if (lane_en) m_armed = 1; end
    need = lane_en && m_armed && m_pos == 0 && slot_mask[m_slot] && !m_skip;
    take = need && vld;
    miss = need && !vld;
    rq = !lane_en ? "R2" : (!m_armed ? "R2" : (m_skip ? "R12" :
         (!slot_mask[m_slot] ? "R9" : "R10")));
    if (m_pos == 0) m_live = take;
    if (take) m_word = d;
    if (miss && frame_align) m_skip = 1;
    base = m_live ? model_bit(m_word, m_pos) : 1'b0;
    exp_out = !lane_en ? 1'b0 : (fmt == 2'b00 ? m_prev : base);
    m_prev = lane_en ? base : 1'b0;
    if (m_pos == cfg_slot_len() - 1) begin
      m_pos = 0;
      m_slot = (m_slot == int'(slot_last)) ? 0 : m_slot + 1;
    end else m_pos++;
    #1;
    ck(s_ready == take, rq, s_ready, take);
    @(posedge clk);
    @(negedge clk);
    ck(sdata_out == exp_out, m_skip ? "R12" : fmt_req(), sdata_out, exp_out);
    ck(underflow == miss, "R11", underflow, miss);
    bclk_tick = 1'b0; frame_start = 1'b0; s_valid = 1'b0;
    @(posedge clk);
    @(negedge clk);
    ck(sdata_out == exp_out, "R3", sdata_out, exp_out);
    ck(underflow == 1'b0, "R11", underflow, 0);
  endtask

  task automatic run_cfg(input bit [1:0] f, input bit [1:0] ds, input bit s32,
                         input bit [3:0] last, input bit [15:0] mask,
                         input bit align, input int nframes, input int pct);
    lane_en = 1'b0;
    fmt = f; dsize = ds; slot32 = s32; slot_last = last; slot_mask = mask;
    frame_align = align;
    repeat (3) do_tick(1'b0, 1'b1);   // R2: idle lane
    lane_en = 1'b1;
    repeat (2) do_tick(1'b0, 1'b1);   // R2: enabled but not armed
    for (int fr = 0; fr < nframes; fr++) begin
      for (int b = 0; b < cfg_slot_len() * (int'(last) + 1); b++)
        do_tick(b == 0, ($urandom % 100) < pct);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL R3 watchdog actual=hung expected=done");
    $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1
    ck(sdata_out == 1'b0, "R1", sdata_out, 0);
    ck(s_ready == 1'b0, "R1", s_ready, 0);
    ck(underflow == 1'b0, "R1", underflow, 0);
    rst_n = 1'b1;
    @(negedge clk);
    ck(sdata_out == 1'b0 && underflow == 1'b0, "R1", sdata_out, 0);

    run_cfg(2'b01, 2'b00, 1'b0, 4'd1, 16'h0003, 1'b0, 2, 100);  // R5
    run_cfg(2'b10, 2'b00, 1'b1, 4'd3, 16'h000A, 1'b0, 2, 100);  // R6 16 in 32
    run_cfg(2'b10, 2'b01, 1'b0, 4'd1, 16'h0003, 1'b0, 2, 100);  // R6 24 bit
    run_cfg(2'b00, 2'b10, 1'b0, 4'd1, 16'h0003, 1'b0, 3, 100);  // R7
    run_cfg(2'b00, 2'b00, 1'b0, 4'd3, 16'h000F, 1'b0, 2, 100);  // R7 16-bit slots
    run_cfg(2'b11, 2'b11, 1'b0, 4'd7, 16'h00A5, 1'b0, 2, 100);  // R8 R4 R9
    run_cfg(2'b01, 2'b11, 1'b0, 4'd1, 16'h0003, 1'b0, 2, 100);  // R4 reserved size
    run_cfg(2'b01, 2'b00, 1'b0, 4'd7, 16'h00FF, 1'b1, 3, 60);   // R12 align on
    run_cfg(2'b01, 2'b00, 1'b0, 4'd7, 16'h00FF, 1'b0, 3, 60);   // R12 align off
    run_cfg(2'b10, 2'b00, 1'b0, 4'd15, 16'hFFFF, 1'b0, 1, 90);  // R3 16 slots
    run_cfg(2'b01, 2'b00, 1'b0, 4'd5, 16'h0000, 1'b0, 1, 100);  // R9 all masked
    for (int i = 0; i < 12; i++) begin
      run_cfg(2'($urandom), 2'($urandom), 1'($urandom), 4'($urandom % 8),
              16'($urandom), 1'($urandom), 2, 85);
    end
    lane_en = 1'b0;
    repeat (2) do_tick(1'b1, 1'b1);   // R2: frame strobes ignored when idle
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule